// File: doc/BRIEF.md
# Core Module Control Register File

This block is the control and identification register set of a processor core module. It sits on a plain word-oriented read/write bus that presents byte offsets. Bits [1:0] of the offset are ignored, and the remaining bits select a 32-bit register. Reads are combinational from the offset; a write takes effect at the rising clock edge on which the write strobe is high.

The block holds several kinds of state:
- constant identification words;
- two clock-setting registers that a magic key written into a lock register protects;
- a control register whose bits light an LED, swap the memory at address zero, and request a system reset;
- two flag registers, each with separate set and clear addresses;
- memory and init configuration words;
- a free-running count that advances at a fixed 24 MHz rate, derived from the bus clock by a fractional accumulator;
- a 32-byte memory-presence window returned one byte per word;
- a one-bit software interrupt with separate normal and fast enable masks.

Top module: `cm_ctrl_regs`

## Requirements
- R1: Word 0 reads 0x411A3001, word 1 reads 0 and word 4 reads 0x00100000; writes to these words change nothing.
- R2: A write to word 5 keeps only wdata[15:0] as the lock value (reset 0). A read of word 5 returns 0x0001A05F while the lock value is 0xA05F, and otherwise returns the lock value zero-extended.
- R3: Word 2 (main oscillator, reset 0x01000048) and word 7 (auxiliary oscillator, reset 0x0007FEFF) take a write only while the lock value is 0xA05F; otherwise the write is dropped.
- R4: A write to word 3 stores wdata[0] and wdata[2]. Word 3 reads back {29'b0, bit2, 1'b0, bit0}. Output led follows bit 0 and output remap follows bit 2 (1 puts RAM at address zero, 0 puts boot memory there). Both reset to 0.
- R5: A write to word 3 with wdata[3]=1 drives reset_req high for exactly the one cycle after the write edge; otherwise reset_req stays low.
- R6: Word 12 reads the flags. A write to word 12 ORs wdata into them and a write to word 13 clears the bits set in wdata. Words 14 and 15 do the same for a second, nonvolatile flag register. Both reset to 0.
- R7: Byte offsets 0x100..0x17F read presence byte (offset-0x100)/4 in bits [7:0], with upper bits 0. Bytes 0..30 are 128,8,4,11,9,1,64,0,2,160,160,0,0,8,0,1,14,4,28,1,2,32,192,0,0,0,0,48,40,48,40. Byte 31 follows R9. Offsets 0x180..0x1FF read 0.
- R8: Word 10 is a read-only 32-bit count, 0 at reset, that gains exactly floor(n*REF_HZ/CLK_HZ) over the first n clock edges after reset and never steps by more than 1 per cycle.
- R9: Word 8 resets to 0x00011122 with bits [4:2] set by MEM_MB: 1 for 32 MB or more, 2 for 64 MB or more, 3 for 128 MB or more, 4 for 256 MB or more, and 0 below 32 MB. Presence byte 31 is 4, 16, 32, 64 or 2 in the same cases. Word 9 resets to 0x00000112.
- R10: Words 8 and 9 take any written value and read it back.
- R11: Normal interrupt path. Word 17 reads the soft level in bit 0. Word 16 reads that level ANDed with the enable mask. Word 18 reads the mask; writes to 18 and 19 set and clear mask bits. Writes with wdata[0]=1 to words 20 and 21 set and clear the soft level, and word 20 reads the level.
- R12: Fast interrupt path. Words 24, 25, 26 and 27 behave as words 16, 17, 18 and 19, using a separate mask and the same soft level.
- R13: Unmapped words, including 6, 11, 22 and words at or above 128, and voltage words 32..35 read 0. Writes to them leave every register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Combinational read data for addr |
| remap | output | 1 | 1 maps RAM at address zero, 0 maps boot memory |
| reset_req | output | 1 | One-cycle system reset request |
| led | output | 1 | LED drive |

## Verification
Almost every piece of state is visible on rdata in the same cycle as the edge that changed it. A wrong lock compare, flag mask or enable mask therefore appears at the next read of that word, and the reference model in the bench catches it there. A wrong control bit shows at once on led or remap. A reset request that is missing or lasts too long shows on reset_req in the cycle after the write. A counter that drifts in rate is exposed by the exact count it gains over a fixed window of edges.

// File: rtl/cm_ctrl_regs.sv
module cm_ctrl_regs #(
  parameter int ADDR_W = 12,
  parameter int MEM_MB = 128,
  parameter int CLK_HZ = 50_000_000,
  parameter int REF_HZ = 24_000_000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              remap,
  output logic              reset_req,
  output logic              led
);
  localparam int WORD_W = ADDR_W - 2;
  localparam int ACC_W  = $clog2(CLK_HZ) + 1;
  localparam logic [15:0] UNLOCK_KEY = 16'hA05F;
  localparam logic [2:0] SIZE_CODE = (MEM_MB >= 256) ? 3'd4 : (MEM_MB >= 128) ? 3'd3 :
                                     (MEM_MB >= 64)  ? 3'd2 : (MEM_MB >= 32)  ? 3'd1 : 3'd0;
  localparam logic [7:0] SIZE_BYTE = (MEM_MB >= 256) ? 8'd64 : (MEM_MB >= 128) ? 8'd32 :
                                     (MEM_MB >= 64)  ? 8'd16 : (MEM_MB >= 32)  ? 8'd4 : 8'd2;

  localparam logic [WORD_W-1:0] W_ID     = WORD_W'(0);
  localparam logic [WORD_W-1:0] W_PROC   = WORD_W'(1);
  localparam logic [WORD_W-1:0] W_OSC    = WORD_W'(2);
  localparam logic [WORD_W-1:0] W_CTRL   = WORD_W'(3);
  localparam logic [WORD_W-1:0] W_STAT   = WORD_W'(4);
  localparam logic [WORD_W-1:0] W_LOCK   = WORD_W'(5);
  localparam logic [WORD_W-1:0] W_AUX    = WORD_W'(7);
  localparam logic [WORD_W-1:0] W_SDRAM  = WORD_W'(8);
  localparam logic [WORD_W-1:0] W_INIT   = WORD_W'(9);
  localparam logic [WORD_W-1:0] W_COUNT  = WORD_W'(10);
  localparam logic [WORD_W-1:0] W_FSET   = WORD_W'(12);
  localparam logic [WORD_W-1:0] W_FCLR   = WORD_W'(13);
  localparam logic [WORD_W-1:0] W_NVSET  = WORD_W'(14);
  localparam logic [WORD_W-1:0] W_NVCLR  = WORD_W'(15);
  localparam logic [WORD_W-1:0] W_ISTAT  = WORD_W'(16);
  localparam logic [WORD_W-1:0] W_IRAW   = WORD_W'(17);
  localparam logic [WORD_W-1:0] W_IENSET = WORD_W'(18);
  localparam logic [WORD_W-1:0] W_IENCLR = WORD_W'(19);
  localparam logic [WORD_W-1:0] W_SWSET  = WORD_W'(20);
  localparam logic [WORD_W-1:0] W_SWCLR  = WORD_W'(21);
  localparam logic [WORD_W-1:0] W_FSTAT  = WORD_W'(24);
  localparam logic [WORD_W-1:0] W_FRAW   = WORD_W'(25);
  localparam logic [WORD_W-1:0] W_FENSET = WORD_W'(26);
  localparam logic [WORD_W-1:0] W_FENCLR = WORD_W'(27);

  logic [WORD_W-1:0] word;
  logic [31:0] osc_q, aux_q, sdram_q, init_q, flags_q, nvflags_q, irq_en_q, fiq_en_q, cnt_q;
  logic [15:0] lock_q;
  logic        led_q, remap_q, soft_q, reset_req_q, unlocked, in_window, unused_bits;
  logic [ACC_W-1:0] acc_q, acc_sum;
  logic        tick;

  assign word        = addr[ADDR_W-1:2];
  assign unused_bits = ^addr[1:0];
  assign unlocked    = (lock_q == UNLOCK_KEY);
  assign in_window   = (addr[ADDR_W-1:7] == (ADDR_W-7)'(2));
  assign led         = led_q;
  assign remap       = remap_q;
  assign reset_req   = reset_req_q;

  function automatic logic [7:0] presence_byte(input logic [4:0] idx);
    case (idx)
      5'd0:  return 8'd128;  5'd1:  return 8'd8;    5'd2:  return 8'd4;    5'd3:  return 8'd11;
      5'd4:  return 8'd9;    5'd5:  return 8'd1;    5'd6:  return 8'd64;   5'd8:  return 8'd2;
      5'd9:  return 8'd160;  5'd10: return 8'd160;  5'd13: return 8'd8;    5'd15: return 8'd1;
      5'd16: return 8'd14;   5'd17: return 8'd4;    5'd18: return 8'd28;   5'd19: return 8'd1;
      5'd20: return 8'd2;    5'd21: return 8'd32;   5'd22: return 8'd192;  5'd27: return 8'd48;
      5'd28: return 8'd40;   5'd29: return 8'd48;   5'd30: return 8'd40;   5'd31: return SIZE_BYTE;
      default: return 8'd0;
    endcase
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_q       <= 32'h0100_0048;
      aux_q       <= 32'h0007_FEFF;
      sdram_q     <= 32'h0001_1122 | {27'd0, SIZE_CODE, 2'd0};
      init_q      <= 32'h0000_0112;
      lock_q      <= '0;
      led_q       <= 1'b0;
      remap_q     <= 1'b0;
      reset_req_q <= 1'b0;
      flags_q     <= '0;
      nvflags_q   <= '0;
      irq_en_q    <= '0;
      fiq_en_q    <= '0;
      soft_q      <= 1'b0;
    end else begin
      reset_req_q <= 1'b0;
      if (wr_en) begin
        case (word)
          W_OSC:    if (unlocked) osc_q <= wdata;
          W_AUX:    if (unlocked) aux_q <= wdata;
          W_LOCK:   lock_q <= wdata[15:0];
          W_CTRL: begin
            led_q       <= wdata[0];
            remap_q     <= wdata[2];
            reset_req_q <= wdata[3];
          end
          W_SDRAM:  sdram_q   <= wdata;
          W_INIT:   init_q    <= wdata;
          W_FSET:   flags_q   <= flags_q | wdata;
          W_FCLR:   flags_q   <= flags_q & ~wdata;
          W_NVSET:  nvflags_q <= nvflags_q | wdata;
          W_NVCLR:  nvflags_q <= nvflags_q & ~wdata;
          W_IENSET: irq_en_q  <= irq_en_q | wdata;
          W_IENCLR: irq_en_q  <= irq_en_q & ~wdata;
          W_FENSET: fiq_en_q  <= fiq_en_q | wdata;
          W_FENCLR: fiq_en_q  <= fiq_en_q & ~wdata;
          W_SWSET:  if (wdata[0]) soft_q <= 1'b1;
          W_SWCLR:  if (wdata[0]) soft_q <= 1'b0;
          default: ;
        endcase
      end
    end
  end

  assign acc_sum = acc_q + ACC_W'(REF_HZ);
  assign tick    = (acc_sum >= ACC_W'(CLK_HZ));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      cnt_q <= '0;
    end else begin
      acc_q <= tick ? acc_sum - ACC_W'(CLK_HZ) : acc_sum;
      if (tick) cnt_q <= cnt_q + 32'd1;
    end
  end

  always_comb begin
    rdata = '0;
    if (in_window) begin
      rdata = {24'd0, presence_byte(addr[6:2])};
    end else begin
      case (word)
        W_ID:     rdata = 32'h411A_3001;
        W_PROC:   rdata = 32'h0;
        W_OSC:    rdata = osc_q;
        W_CTRL:   rdata = {29'd0, remap_q, 1'b0, led_q};
        W_STAT:   rdata = 32'h0010_0000;
        W_LOCK:   rdata = unlocked ? 32'h0001_A05F : {16'd0, lock_q};
        W_AUX:    rdata = aux_q;
        W_SDRAM:  rdata = sdram_q;
        W_INIT:   rdata = init_q;
        W_COUNT:  rdata = cnt_q;
        W_FSET:   rdata = flags_q;
        W_NVSET:  rdata = nvflags_q;
        W_ISTAT:  rdata = {31'd0, soft_q} & irq_en_q;
        W_IRAW:   rdata = {31'd0, soft_q};
        W_IENSET: rdata = irq_en_q;
        W_SWSET:  rdata = {31'd0, soft_q};
        W_FSTAT:  rdata = {31'd0, soft_q} & fiq_en_q;
        W_FRAW:   rdata = {31'd0, soft_q};
        W_FENSET: rdata = fiq_en_q;
        default:  rdata = '0;
      endcase
    end
  end

  assert_lock_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(lock_q) |-> $past(wr_en && word == W_LOCK));

  assert_osc_gated_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(osc_q) || !$stable(aux_q)) |-> $past(lock_q) == UNLOCK_KEY);

  assert_reset_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |-> $past(wr_en && word == W_CTRL && wdata[3]));

  assert_reset_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reset_req |=> !reset_req);

  assert_flag_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && word == W_FCLR) |=> (flags_q & $past(wdata)) == 32'd0);

  assert_count_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) + 32'd1));
endmodule

// File: tb/cm_ctrl_regs_tb.sv
module cm_ctrl_regs_tb;
  localparam int ADDR_W = 12;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic remap, reset_req, led;
  int vectors = 0, miscompares = 0, cycles = 0;

  logic [31:0] m_osc, m_aux, m_sdram, m_init, m_flags, m_nv, m_ien, m_fen;
  logic [15:0] m_lock;
  logic m_led, m_remap, m_soft;

  cm_ctrl_regs #(.ADDR_W(ADDR_W), .MEM_MB(128)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .remap(remap), .reset_req(reset_req), .led(led));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog: got %0d cycles expected fewer", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vectors++;
    if (got !== exp) begin
      miscompares++;
      $display("FAIL %s: got %08h expected %08h", tag, got, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input int i);
    logic [7:0] t [0:30] = '{128,8,4,11,9,1,64,0,2,160,160,0,0,8,0,1,14,4,28,1,2,32,192,0,0,0,0,48,40,48,40};
    if (i == 31) return 8'd32;
    return t[i];
  endfunction

  function automatic logic [31:0] model_read(input int a);
    int w = a >> 2;
    if (a >= 'h100 && a < 'h180) return {24'd0, exp_byte((a - 'h100) >> 2)};
    case (w)
      0: return 32'h411A3001;
      2: return m_osc;
      3: return {29'd0, m_remap, 1'b0, m_led};
      4: return 32'h00100000;
      5: return (m_lock == 16'hA05F) ? 32'h1A05F : {16'd0, m_lock};
      7: return m_aux;
      8: return m_sdram;
      9: return m_init;
      12: return m_flags;
      14: return m_nv;
      16: return {31'd0, m_soft} & m_ien;
      17, 20, 25: return {31'd0, m_soft};
      18: return m_ien;
      24: return {31'd0, m_soft} & m_fen;
      26: return m_fen;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input int a);
    int w = a >> 2;
    if (a >= 'h100 && a < 'h200) return "R7";
    case (w)
      0, 1, 4: return "R1";
      5: return "R2";
      2, 7: return "R3";
      3: return "R4";
      8, 9: return "R10";
      12, 13, 14, 15: return "R6";
      16, 17, 18, 19, 20, 21: return "R11";
      24, 25, 26, 27: return "R12";
      default: return "R13";
    endcase
  endfunction

  task automatic model_write(input int w, input logic [31:0] d);
    case (w)
      2: if (m_lock == 16'hA05F) m_osc = d;
      7: if (m_lock == 16'hA05F) m_aux = d;
      3: begin m_led = d[0]; m_remap = d[2]; end
      5: m_lock = d[15:0];
      8: m_sdram = d;
      9: m_init = d;
      12: m_flags |= d;
      13: m_flags &= ~d;
      14: m_nv |= d;
      15: m_nv &= ~d;
      18: m_ien |= d;
      19: m_ien &= ~d;
      26: m_fen |= d;
      27: m_fen &= ~d;
      20: if (d[0]) m_soft = 1'b1;
      21: if (d[0]) m_soft = 1'b0;
      default: ;
    endcase
  endtask

  task automatic bus_write(input int w, input logic [31:0] d);
    @(negedge clk);
    addr = ADDR_W'(w << 2); wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    #1;
    model_write(w, d);
    check("R5 reset_req", {31'd0, reset_req}, {31'd0, (w == 3) && d[3]});
    check("R4 led/remap", {30'd0, remap, led}, {30'd0, m_remap, m_led});
  endtask

  task automatic bus_read(input int a, output logic [31:0] v);
    @(negedge clk);
    addr = ADDR_W'(a);
    #1;
    v = rdata;
  endtask

  task automatic read_check(input int a);
    logic [31:0] v;
    bus_read(a, v);
    check(tag_of(a), v, model_read(a));
  endtask

  initial begin
    logic [31:0] c0, c1;
    int words [30] = '{0,1,2,3,4,5,6,7,8,9,11,12,13,14,15,16,17,18,19,20,21,22,24,25,26,27,32,35,40,200};
    m_osc = 32'h01000048; m_aux = 32'h0007FEFF; m_sdram = 32'h0001112E; m_init = 32'h112;
    m_flags = 0; m_nv = 0; m_ien = 0; m_fen = 0; m_lock = 0; m_led = 0; m_remap = 0; m_soft = 0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state R9, R1, R4
    bus_read(8 << 2, c0); check("R9 sdram reset", c0, 32'h0001112E);
    bus_read(9 << 2, c0); check("R9 init reset", c0, 32'h00000112);
    bus_read(2 << 2, c0); check("R9 osc reset", c0, 32'h01000048);
    bus_read(7 << 2, c0); check("R9 aux reset", c0, 32'h0007FEFF);
    bus_read('h17C, c0);  check("R9 size byte", c0, 32'd32);
    check("R4 outputs reset", {29'd0, reset_req, remap, led}, 32'd0);
    read_check(0); read_check(4); read_check(1 << 2);

    // R8 counter rate: 1000 edges at 50 MHz gives 480 ticks
    bus_read(10 << 2, c0);
    repeat (1000) @(negedge clk);
    #1; c1 = rdata;
    check("R8 count delta", c1 - c0, 32'd480);

    // R2 / R3 lock gating
    bus_write(2, 32'hDEADBEEF); read_check(2 << 2);
    bus_write(5, 32'h1234A05F); read_check(5 << 2);
    bus_write(2, 32'hCAFE0001); read_check(2 << 2);
    bus_write(7, 32'h00000077); read_check(7 << 2);
    bus_write(5, 32'h0000A05E); read_check(5 << 2);
    bus_write(7, 32'h55555555); read_check(7 << 2);

    // R4 / R5 control
    bus_write(3, 32'hFFFFFFFF); read_check(3 << 2);
    bus_write(3, 32'h00000008); read_check(3 << 2);

    // R6 flags
    bus_write(12, 32'hF0F0000F); bus_write(13, 32'h30000003); read_check(12 << 2);
    bus_write(14, 32'h00FF0000); bus_write(15, 32'h000F0000); read_check(14 << 2);

    // R11 / R12 interrupt
    bus_write(20, 32'h1); bus_write(18, 32'h3); bus_write(26, 32'h1);
    read_check(16 << 2); read_check(24 << 2); read_check(17 << 2);
    bus_write(19, 32'h1); read_check(16 << 2);
    bus_write(21, 32'h0); read_check(25 << 2);
    bus_write(21, 32'h1); read_check(20 << 2); read_check(24 << 2);

    // R7 window, R13 unmapped
    read_check('h100); read_check('h124); read_check('h180); read_check('h1FC);
    bus_write(33, 32'hFFFFFFFF); bus_write(6, 32'hFFFFFFFF); bus_write(300, 32'hFFFFFFFF);
    read_check(33 << 2); read_check(12 << 2); read_check(8 << 2); read_check(300 << 2);
    bus_write(8, 32'h12345678); read_check(8 << 2);

    // constrained random mix
    for (int i = 0; i < 800; i++) begin
      int w = words[$urandom_range(0, 29)];
      logic [31:0] d = $urandom();
      if (w == 5 && $urandom_range(0, 2) == 0) d = 32'h0000A05F;
      if ($urandom_range(0, 1) == 1) bus_write(w, d);
      else if ($urandom_range(0, 3) == 0) read_check('h100 + 4 * $urandom_range(0, 63));
      else read_check(w << 2);
    end

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule